// File: doc/BRIEF.md
# Transmit Collision Counter

This block follows one outgoing frame from its transmit command to its end and counts the collisions that the frame runs into along the way. A transmit-start pulse opens a transmission. It clears the 4-bit collision count and both status bits. While the transmission is open, each one-cycle collision pulse adds one to the count and marks the frame as having collided. A transmit-done pulse closes the transmission. The count and the status bits then hold steady so the host can read them at any later time.

The block also enforces the attempt limit. The 16th collision on one frame is treated as excessive. That collision abandons the frame, sets the aborted bit and lets the count wrap back to zero. It also raises a one-cycle abandon pulse that tells the transmit machinery to stop retrying. Collision pulses that arrive while no transmission is open are ignored.

Top module: `tx_coll_tally`

## Requirements
- R1: After reset the count is 0, the collided and aborted bits are 0, the active output is 0 and the abandon output is 0.
- R2: A tx_start pulse makes the next-cycle count 0, collided 0, aborted 0 and active 1. A collision pulse in the same cycle as tx_start is not counted.
- R3: While active, each collision pulse raises the count by exactly one and sets collided. Both changes are visible in the cycle after the pulse.
- R4: The 16th collision (ATTEMPT_LIMIT) within one transmission sets aborted, leaves the count at 0, keeps collided at 1 and clears active.
- R5: The abandon output is high for exactly the one cycle that follows the limit-reaching collision, and it is low at all other times.
- R6: A transmission that ends with tx_done and had no collisions reports count 0, collided 0 and aborted 0.
- R7: tx_done while active clears active. The count and the status bits then hold their values until the next tx_start.
- R8: Collision pulses and tx_done pulses that arrive while active is 0 have no effect on the count, the status bits or active.
- R9: A collision pulse and tx_done in the same active cycle are both honoured: the collision is counted and the transmission ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | One-cycle pulse: a new transmit command |
| coll_pulse | input | 1 | One-cycle pulse per collision on the current attempt |
| tx_done | input | 1 | One-cycle pulse: the transmission has ended |
| coll_count | output | 4 | Collisions seen on the current or last frame |
| collided | output | 1 | At least one collision occurred on the frame |
| aborted | output | 1 | Frame abandoned after excessive collisions |
| tx_active | output | 1 | A transmission is open |
| tx_abandon | output | 1 | One-cycle pulse: attempt limit hit, stop retrying |

## Verification
The bench sweeps the number of collisions per frame from 0 to 20. It runs each count twice: once with the collision pulses back to back and once with idle cycles between them. This separates the normal counting range from the wrap-and-abort case at 16 and from the ignored pulses that come after an abort. After every frame, stray collision and done pulses show whether the idle state is truly frozen. Dedicated cases put a collision in the same cycle as start, and another collision in the same cycle as done, to show which event takes priority.

// File: rtl/tx_coll_tally_pkg.sv
package tx_coll_tally_pkg;

    typedef struct packed {
        logic active;
        logic collided;
        logic aborted;
        logic abandon;
    } txct_flags_t;

    localparam txct_flags_t TXCT_FLAGS_RESET = '{active: 1'b0, collided: 1'b0,
                                                 aborted: 1'b0, abandon: 1'b0};

endpackage

// File: rtl/txct_limit.sv
module txct_limit #(
    parameter int CNT_W         = 4,
    parameter int ATTEMPT_LIMIT = 16
) (
    input  logic [CNT_W-1:0] count_q,
    output logic             last_try
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ATTEMPT_LIMIT - 1);

    always_comb begin
        last_try = (count_q == LAST_IDX);
    end
endmodule

// File: rtl/txct_next.sv
module txct_next
    import tx_coll_tally_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             tx_start,
    input  logic             coll_pulse,
    input  logic             tx_done,
    input  logic             last_try,
    input  logic [CNT_W-1:0] count_q,
    input  txct_flags_t      flags_q,
    output logic [CNT_W-1:0] count_d,
    output txct_flags_t      flags_d
);
    always_comb begin
        count_d         = count_q;
        flags_d         = flags_q;
        flags_d.abandon = 1'b0;
        if (tx_start) begin
            count_d          = '0;
            flags_d.collided = 1'b0;
            flags_d.aborted  = 1'b0;
            flags_d.active   = 1'b1;
        end else if (flags_q.active) begin
            if (coll_pulse) begin
                flags_d.collided = 1'b1;
                if (last_try) begin
                    count_d         = '0;
                    flags_d.aborted = 1'b1;
                    flags_d.active  = 1'b0;
                    flags_d.abandon = 1'b1;
                end else begin
                    count_d = count_q + CNT_W'(1);
                    if (tx_done) begin
                        flags_d.active = 1'b0;
                    end
                end
            end else if (tx_done) begin
                flags_d.active = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_coll_tally.sv
module tx_coll_tally
    import tx_coll_tally_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int ATTEMPT_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             coll_pulse,
    input  logic             tx_done,
    output logic [CNT_W-1:0] coll_count,
    output logic             collided,
    output logic             aborted,
    output logic             tx_active,
    output logic             tx_abandon
);
    logic [CNT_W-1:0] count_d, count_q;
    txct_flags_t      flags_d, flags_q;
    logic             last_try;

    txct_limit #(.CNT_W(CNT_W), .ATTEMPT_LIMIT(ATTEMPT_LIMIT)) u_limit (
        .count_q  (count_q),
        .last_try (last_try)
    );

    txct_next #(.CNT_W(CNT_W)) u_next (
        .tx_start   (tx_start),
        .coll_pulse (coll_pulse),
        .tx_done    (tx_done),
        .last_try   (last_try),
        .count_q    (count_q),
        .flags_q    (flags_q),
        .count_d    (count_d),
        .flags_d    (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            flags_q <= TXCT_FLAGS_RESET;
        end else begin
            count_q <= count_d;
            flags_q <= flags_d;
        end
    end

    assign coll_count = count_q;
    assign collided   = flags_q.collided;
    assign aborted    = flags_q.aborted;
    assign tx_active  = flags_q.active;
    assign tx_abandon = flags_q.abandon;

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (coll_count == '0) && !collided && !aborted && tx_active);

    // R3
    coll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && coll_pulse && !tx_start && !last_try)
        |=> (coll_count == $past(coll_count) + CNT_W'(1)) && collided);

    // R4
    limit_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && coll_pulse && !tx_start && last_try)
        |=> aborted && (coll_count == '0) && !tx_active);

    // R5
    abandon_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abandon |=> !tx_abandon);

    // R8
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !tx_start)
        |=> $stable(coll_count) && $stable(collided) && $stable(aborted) && !tx_active);

    // R7
    done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_done && !tx_start) |=> !tx_active);
endmodule

// File: tb/tb_tx_coll_tally.sv
module tb_tx_coll_tally;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0;
    logic       coll_pulse = 1'b0;
    logic       tx_done = 1'b0;
    logic [3:0] coll_count;
    logic       collided, aborted, tx_active, tx_abandon;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tx_coll_tally dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .coll_pulse(coll_pulse),
        .tx_done(tx_done), .coll_count(coll_count), .collided(collided),
        .aborted(aborted), .tx_active(tx_active), .tx_abandon(tx_abandon)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, int cnt, int col, int abt, int act, int abn);
        chk(req, "count", int'(coll_count), cnt);
        chk(req, "collided", int'(collided), col);
        chk(req, "aborted", int'(aborted), abt);
        chk(req, "active", int'(tx_active), act);
        chk(req, "abandon", int'(tx_abandon), abn);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_frame(int n, int gap);
        int exp_cnt = 0;
        int exp_col = 0;
        int exp_abt = 0;
        int exp_act = 1;
        tx_start = 1'b1;
        step();
        tx_start = 1'b0;
        chk_all("R2", 0, 0, 0, 1, 0);
        for (int i = 1; i <= n; i++) begin
            int abn = 0;
            coll_pulse = 1'b1;
            step();
            coll_pulse = 1'b0;
            if (exp_act == 1) begin
                exp_col = 1;
                if (i == 16) begin
                    exp_cnt = 0; exp_abt = 1; exp_act = 0; abn = 1;
                end else begin
                    exp_cnt = i;
                end
            end
            chk_all((i == 16) ? "R4" : ((i > 16) ? "R8" : "R3"),
                    exp_cnt, exp_col, exp_abt, exp_act, abn);
            for (int g = 0; g < gap; g++) begin
                step();
                chk_all("R5", exp_cnt, exp_col, exp_abt, exp_act, 0);
            end
        end
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
        chk_all((n == 0) ? "R6" : "R7", exp_cnt, exp_col, exp_abt, 0, 0);
        coll_pulse = 1'b1;
        step();
        coll_pulse = 1'b0;
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
        step();
        chk_all("R8", exp_cnt, exp_col, exp_abt, 0, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        chk_all("R1", 0, 0, 0, 0, 0);
        step();
        rst_n = 1'b1;
        step();
        chk_all("R1", 0, 0, 0, 0, 0);
        // R8: idle collisions before any transmission
        coll_pulse = 1'b1; step(); coll_pulse = 1'b0; step();
        chk_all("R8", 0, 0, 0, 0, 0);

        for (int gap = 0; gap < 2; gap++) begin
            for (int n = 0; n <= 20; n++) begin
                run_frame(n, gap);
            end
        end

        // R2: collision in same cycle as start is not counted
        tx_start = 1'b1; coll_pulse = 1'b1;
        step();
        tx_start = 1'b0; coll_pulse = 1'b0;
        chk_all("R2", 0, 0, 0, 1, 0);
        // R9: collision together with done
        coll_pulse = 1'b1; step(); coll_pulse = 1'b0;
        coll_pulse = 1'b1; tx_done = 1'b1; step();
        coll_pulse = 1'b0; tx_done = 1'b0;
        chk_all("R9", 2, 1, 0, 0, 0);
        step();
        chk_all("R7", 2, 1, 0, 0, 0);

        // R4: 15 collisions then done at the 16th pulse still aborts
        tx_start = 1'b1; step(); tx_start = 1'b0;
        for (int i = 0; i < 15; i++) begin
            coll_pulse = 1'b1; step();
        end
        tx_done = 1'b1; step();
        coll_pulse = 1'b0; tx_done = 1'b0;
        chk_all("R4", 0, 1, 1, 0, 1);
        step();
        chk_all("R5", 0, 1, 1, 0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule